// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a supervision timer. Software must restart it regularly, or it raises a reset request. It is driven through one 8-bit control byte, written with a strobe. Writes with the top bit set are treated as keys. One key starts the timer and restarts its count. One key opens a short window, and a second key written inside that window stops the timer. A further key sets a lock that stays set until reset, and it blocks any later stop. Writes with the top bit clear choose one of eight timeout lengths. The lengths are powers of four of the clock period, from 64 to 1048576 cycles.

When the count reaches the chosen length while the timer is running, the block raises a reset request for one clock and starts the count again. A newly chosen length takes effect only at the next restart of the count. A status byte always shows the length code, the running flag and the lock flag.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `rd_data` reads 0x17 (length code 7, running, unlocked) and `rst_req` is low.
- R2: A write with bit 7 clear stores `wr_data[2:0]` as the length code. The other bits of that write are dropped. `rd_data` shows the code in [2:0], running in bit 4 and lock in bit 5. All other bits read zero.
- R3: With code n active, `rst_req` is high for exactly one cycle, 4^(n+3) rising edges after the count restarts. The count then restarts by itself, so the pulse repeats with that period.
- R4: Writing 0xA5 sets the running flag and restarts the count, including in the middle of a count.
- R5: Writing 0xDE and then 0xAD, with the second write 1 to 4 edges after the first, clears the running flag. While the timer is stopped, `rst_req` stays low.
- R6: If 0xAD comes 5 or more edges after 0xDE, or any other write comes between the two, the timer keeps running.
- R7: Writing 0xFF sets the lock. While the lock is set, the stop sequence has no effect. Only reset clears the lock.
- R8: A change of length code leaves the current count alone. The new length applies from the next restart of the count.
- R9: A write with bit 7 set that is not 0xA5, 0xDE, 0xAD or 0xFF changes no state, and it cancels an open stop window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte being written |
| rd_data | output | 8 | Status byte: code, running flag, lock flag |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A write takes effect at the rising edge where the strobe is sampled. The status byte therefore changes right after that edge, and the bench reads it at the next falling edge. The reset request is registered. It rises just after the 4^(n+3)-th edge that follows the restarting write. The bench counts falling edges from the end of each write and compares `rst_req` at every one of them against the exact expected edge number. This catches pulses that are early, late, missing or too long, and it holds even when a length change or a second write comes in the middle of a count. Stop-window tests place the 0xAD write exactly 1, 4 and 5 edges after 0xDE, which covers both sides of the window boundary.

// File: rtl/kwd_pkg.sv
// Package: constants shared by the keyed watchdog modules.
// Assumes an 8-bit control byte; key values and status bit positions live here.
package kwd_pkg;
    localparam int          BYTE_W      = 8;
    localparam logic [7:0]  KEY_RUN     = 8'hA5;
    localparam logic [7:0]  KEY_ARM     = 8'hDE;
    localparam logic [7:0]  KEY_STOP    = 8'hAD;
    localparam logic [7:0]  KEY_LOCK    = 8'hFF;
    localparam int          RB_RUN_BIT  = 4;
    localparam int          RB_LOCK_BIT = 5;
    localparam int          LOG4_BASE   = 3;   // code n -> 4^(n+LOG4_BASE) clocks
endpackage

// File: rtl/kwd_key_ctrl.sv
// Module: kwd_key_ctrl
// Decodes control-byte writes into the running flag, lock flag and length code.
// It also tracks the stop window opened by the arm key.
// Assumes one write per clock at most; a write is taken when wr_en_i is high at a rising edge.
module kwd_key_ctrl
    import kwd_pkg::*;
#(
    parameter int CODE_W     = 3,
    parameter int KEY_WINDOW = 4,
    parameter int RESET_CODE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic              run_o,
    output logic              lock_o,
    output logic [CODE_W-1:0] code_o,
    output logic              restart_o
);
    localparam int WIN_W = $clog2(KEY_WINDOW + 1);

    logic [WIN_W-1:0] win_q;

    // Purpose: flag the run key, which restarts the counter in the same edge.
    always_comb restart_o = wr_en_i && (wr_data_i == KEY_RUN);

    // Purpose: update run, lock, code and the stop window from each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o  <= 1'b1;
            lock_o <= 1'b0;
            code_o <= CODE_W'(RESET_CODE);
            win_q  <= '0;
        end else if (wr_en_i) begin
            win_q <= '0;
            if (!wr_data_i[BYTE_W-1]) begin
                code_o <= wr_data_i[CODE_W-1:0];
            end else if (wr_data_i == KEY_RUN) begin
                run_o <= 1'b1;
            end else if (wr_data_i == KEY_ARM) begin
                win_q <= WIN_W'(KEY_WINDOW);
            end else if (wr_data_i == KEY_STOP) begin
                if ((win_q != '0) && !lock_o)
                    run_o <= 1'b0;
            end else if (wr_data_i == KEY_LOCK) begin
                lock_o <= 1'b1;
            end
        end else if (win_q != '0) begin
            win_q <= win_q - WIN_W'(1);
        end
    end

    // R7: the lock never clears while out of reset
    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);

    // R5: the running flag only falls on an unlocked stop-key write
    assert_stop_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_o) |-> $past(wr_en_i && (wr_data_i == KEY_STOP) && !lock_o));

    // R2: the code changes only through a write with bit 7 clear
    assert_code_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || wr_data_i[BYTE_W-1]) |=> $stable(code_o));
endmodule

// File: rtl/kwd_counter.sv
// Module: kwd_counter
// Counts clocks while running and pulses the request at the latched terminal count.
// The length code is latched only when the count restarts.
// Assumes restart_i and run_i come from the key decoder in the same cycle.
module kwd_counter
    import kwd_pkg::*;
#(
    parameter int CODE_W     = 3,
    parameter int RESET_CODE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              req_o
);
    localparam int CNT_W = 2 * ((1 << CODE_W) - 1 + LOG4_BASE);
    localparam int SH_W  = $clog2(CNT_W + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] act_q;
    logic [SH_W-1:0]   shamt;
    logic [CNT_W-1:0]  last_cnt;
    logic              expire;

    // Purpose: derive the last count value 4^(act+base)-1 as a mask of low ones.
    always_comb begin
        shamt    = SH_W'({act_q, 1'b0}) + SH_W'(2 * LOG4_BASE);
        last_cnt = ~({CNT_W{1'b1}} << shamt);
        expire   = run_i && (cnt_q == last_cnt);
    end

    // Purpose: advance, restart or hold the count and register the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= CODE_W'(RESET_CODE);
            req_o <= 1'b0;
        end else if (restart_i || !run_i) begin
            cnt_q <= '0;
            act_q <= code_i;
            req_o <= 1'b0;
        end else if (expire) begin
            cnt_q <= '0;
            act_q <= code_i;
            req_o <= 1'b1;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            req_o <= 1'b0;
        end
    end

    // R3: a request is only raised by a running timer
    assert_req_when_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(run_i));

    // R3: the request lasts one cycle
    assert_req_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    // R4: a run-key write leaves the count at zero
    assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/keyed_watchdog.sv
// Module: keyed_watchdog (top)
// A keyed watchdog: the key decoder drives the counter, and a status byte is read back.
// Assumes a synchronous active-low reset and writes qualified by wr_en.
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int CODE_W     = 3,
    parameter int KEY_WINDOW = 4,
    parameter int RESET_CODE = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       rst_req
);
    logic              run;
    logic              lock;
    logic              restart;
    logic [CODE_W-1:0] code;

    kwd_key_ctrl #(
        .CODE_W(CODE_W), .KEY_WINDOW(KEY_WINDOW), .RESET_CODE(RESET_CODE)
    ) u_keys (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .run_o(run), .lock_o(lock), .code_o(code), .restart_o(restart)
    );

    kwd_counter #(
        .CODE_W(CODE_W), .RESET_CODE(RESET_CODE)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart),
        .code_i(code), .req_o(rst_req)
    );

    // Purpose: assemble the status byte, with unused bits at zero.
    always_comb begin
        rd_data              = '0;
        rd_data[CODE_W-1:0]  = code;
        rd_data[RB_RUN_BIT]  = run;
        rd_data[RB_LOCK_BIT] = lock;
    end
endmodule

// File: tb/keyed_watchdog_test.sv
// Bench: directed scenarios for keyed_watchdog. Each task checks its own results.
// Inputs change and outputs are sampled on falling edges.
module keyed_watchdog_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rst_req;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    keyed_watchdog uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .rst_req(rst_req)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Purpose: record one comparison and print a line on mismatch.
    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Purpose: one write, starting and ending on a falling edge.
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Purpose: over n edges, rst_req must be high exactly at edge p1 and edge p2.
    task automatic watch(input int n, input int p1, input int p2, input string req);
        int bad_k = -1;
        logic bad_v = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (bad_k < 0 && rst_req !== ((k == p1) || (k == p2))) begin
                bad_k = k; bad_v = rst_req;
            end
        end
        check(bad_k, -1, req);
        if (bad_k >= 0) $display("  at edge %0d rst_req=%0b", bad_k, bad_v);
    endtask

    task automatic t_reset();
        do_reset();
        check(rd_data, 8'h17, "R1 status");
        check(rst_req, 1'b0, "R1 rst_req");
    endtask

    task automatic t_interval();
        do_reset();
        wr(8'h7B); check(rd_data, 8'h13, "R2 code 3, upper bits dropped");
        wr(8'h05); check(rd_data, 8'h15, "R2 code 5");
        wr(8'h00); check(rd_data, 8'h10, "R2 code 0");
    endtask

    task automatic t_timeout();
        do_reset();
        wr(8'h00); wr(8'hA5);
        watch(130, 64, 128, "R3 code 0 period 64");
        wr(8'h01); wr(8'hA5);
        watch(520, 256, 512, "R3 code 1 period 256");
        wr(8'h00); wr(8'hA5); idle(40); wr(8'hA5);
        watch(70, 64, -1, "R4 mid-count restart");
    endtask

    task automatic t_no_reload();
        do_reset();
        wr(8'h01); wr(8'hA5); wr(8'h00);
        watch(330, 255, 319, "R8 new code waits for reload");
    endtask

    task automatic t_disable();
        do_reset();
        wr(8'h00); wr(8'hA5); wr(8'hDE); wr(8'hAD);
        check(rd_data, 8'h00, "R5 stop at 1 edge");
        watch(200, -1, -1, "R5 no request while stopped");
        wr(8'hA5);
        check(rd_data, 8'h10, "R4 run key restarts");
        watch(70, 64, -1, "R4 count from run key");
        wr(8'hDE); idle(3); wr(8'hAD);
        check(rd_data, 8'h00, "R5 stop at 4 edges");
    endtask

    task automatic t_window_miss();
        do_reset();
        wr(8'h00); wr(8'hA5);
        wr(8'hDE); idle(4); wr(8'hAD);
        check(rd_data, 8'h10, "R6 stop key 5 edges late");
        wr(8'hDE); wr(8'h00); wr(8'hAD);
        check(rd_data, 8'h10, "R6 write between keys");
    endtask

    task automatic t_ignored();
        do_reset();
        wr(8'h02); wr(8'h9C);
        check(rd_data, 8'h12, "R9 unknown key no change");
        wr(8'hDE); wr(8'h9C); wr(8'hAD);
        check(rd_data, 8'h12, "R9 unknown key cancels window");
    endtask

    task automatic t_lock();
        do_reset();
        wr(8'h00); wr(8'hFF);
        check(rd_data, 8'h30, "R7 lock set");
        wr(8'hDE); wr(8'hAD);
        check(rd_data, 8'h30, "R7 stop blocked");
        wr(8'hA5);
        watch(70, 64, -1, "R7 still expires when locked");
        do_reset();
        check(rd_data, 8'h17, "R7 reset clears lock");
        wr(8'hDE); wr(8'hAD);
        check(rd_data, 8'h07, "R7 stop works after reset");
    endtask

    initial begin
        t_reset();
        t_interval();
        t_timeout();
        t_no_reload();
        t_disable();
        t_window_miss();
        t_ignored();
        t_lock();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule